// File: doc/BRIEF.md
# Power-Fail Sequencer with Shadow-Store Control

This block supervises a supply-good indication and turns it into the control signals a small processor system needs to survive power loss. The system's working RAM has a nonvolatile copy, one byte for each RAM byte. At power-up the sequencer holds the system in reset until the supply is judged good. It then copies every nonvolatile byte back into RAM, and only after that does it release reset.

When the supply fails during normal operation, the sequencer raises an active-low non-maskable interrupt so that the processor can stop. At the same moment it starts copying every RAM byte into its nonvolatile partner. After that copy it keeps watching the supply for a fixed window. If power comes back inside the window, the outage is treated as a momentary dropout: the interrupt is released and the system continues without a reset. If the window expires first, the outage is treated as real. The system goes back to reset, and the next power-up performs a full restore.

The raw supply indication is asynchronous. It passes through a two-stage synchronizer and then a glitch filter before the state machine acts on it. Both copy walks visit addresses 0 to DEPTH-1 in ascending order, one byte per clock, and they are driven out on a shared address port.

Top module: `pfs_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sys_rst` is 1, `nmi_n` is 1, `mem_store` and `mem_recall` are 0, `seq_done` is 0 and `mem_addr` is 0.
- R2: `pwr_ok_async` is synchronized by two flops and then filtered. The filtered level takes a new value only after the synchronized input has differed from it for FILT_LEN consecutive cycles. A change lasting FILT_LEN-1 cycles or less has no effect on any output. The state machine acts one cycle after the filtered level changes.
- R3: After the filtered level turns good in the reset-hold state, a restore walk runs. During the walk `mem_recall` is 1 and `sys_rst` stays 1, and `mem_addr` steps 0,1,…,DEPTH-1, one step per cycle. `sys_rst` drops to 0 in the cycle after address DEPTH-1.
- R4: `seq_done` is high for exactly one cycle: the cycle in which a store or restore walk presents address DEPTH-1.
- R5: When the filtered level turns bad during normal operation, `nmi_n` goes to 0 (asserted) and `mem_store` goes to 1 in the same cycle. A store walk over addresses 0 to DEPTH-1 follows, while `sys_rst` stays 0. At its end every nonvolatile byte equals its RAM byte.
- R6: If the supply turns good again while a store walk is running, the walk still covers all DEPTH addresses. The sequencer then passes through one resume cycle back to normal operation, without raising `sys_rst`.
- R7: After a store walk with the supply still bad, the sequencer waits for up to SHUT_WIN cycles. If the supply turns good inside the wait, `nmi_n` returns to 1 and normal operation resumes, and `sys_rst` stays 0.
- R8: If the wait of R7 runs for SHUT_WIN cycles with the supply still bad, `sys_rst` goes to 1. The next good supply triggers a full restore walk, after which the RAM again holds the stored image.
- R9: If the supply turns bad during a restore walk, the walk stops. The sequencer returns to reset-hold with `sys_rst` at 1 and no store walk at all.
- R10: `mem_store` and `mem_recall` are never high together, and `mem_addr` is 0 whenever neither is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_async | input | 1 | Raw supply-good indication, asynchronous, 1 = good |
| sys_rst | output | 1 | System reset, active high |
| nmi_n | output | 1 | Non-maskable interrupt, active low |
| mem_store | output | 1 | Copy RAM byte at `mem_addr` into nonvolatile memory this cycle |
| mem_recall | output | 1 | Copy nonvolatile byte at `mem_addr` into RAM this cycle |
| mem_addr | output | ADDR_W | Byte address of the current copy step |
| seq_done | output | 1 | One-cycle pulse on the last address of a walk |

## Verification
The bench first sends a supply pulse one cycle shorter than the filter length. A filter that counted off by one would start a restore walk on that pulse. It then drops power in the middle of a restore. A design that finished the walk, or stored a half-restored RAM, would show a stray store walk or a late release of reset. A short dropout that ends while a store is still running checks that the store covers every byte and that the resume happens without a reset. A design that cut the store short would leave stale nonvolatile bytes. Finally, an outage longer than the shutdown window checks that the block takes the full reset-and-restore path, not a resume. A cycle-level reference model is compared against every output on every clock throughout these phases.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD    = 3'd0,
        ST_RECALL        = 3'd1,
        ST_RUN           = 3'd2,
        ST_STORE         = 3'd3,
        ST_SHUTDOWN_WAIT = 3'd4,
        ST_RESUME        = 3'd5
    } pfs_state_e;

    typedef struct packed {
        logic sys_rst;
        logic nmi_n;
        logic store;
        logic recall;
    } pfs_cmd_t;

    // Width of a counter or index able to hold values 0 .. n-1.
    function automatic int unsigned pfs_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // The two states in which the byte walker advances.
    function automatic logic pfs_walking(input pfs_state_e s);
        return (s == ST_RECALL) || (s == ST_STORE);
    endfunction

    // Output command word for each state.
    function automatic pfs_cmd_t pfs_decode(input pfs_state_e s);
        pfs_cmd_t c;
        c.sys_rst = (s == ST_RESET_HOLD) || (s == ST_RECALL);
        c.nmi_n   = !((s == ST_STORE) || (s == ST_SHUTDOWN_WAIT));
        c.store   = (s == ST_STORE);
        c.recall  = (s == ST_RECALL);
        return c;
    endfunction

endpackage

// File: rtl/pfs_sync_filter.sv
module pfs_sync_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic level
);
    localparam int unsigned CW = pfs_pkg::pfs_width(FILT_LEN);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Two-stage synchronizer, then a counter of consecutive disagreeing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
            level  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            if (sync_q[1] == level) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                level <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/pfs_walker.sv
module pfs_walker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = pfs_pkg::pfs_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          last
);
    assign last = run && (addr == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || last) begin
            addr <= '0;
        end else begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/pfs_ctrl.sv
module pfs_ctrl
    import pfs_pkg::*;
#(
    parameter int unsigned SHUT_WIN = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       good,
    input  logic       walk_last,
    output pfs_state_e state
);
    localparam int unsigned WW = pfs_width(SHUT_WIN);

    pfs_state_e    nxt;
    logic [WW-1:0] win_q;
    logic          win_end;

    assign win_end = (win_q == WW'(SHUT_WIN - 1));

    always_comb begin
        nxt = state;
        case (state)
            ST_RESET_HOLD:    if (good) nxt = ST_RECALL;
            ST_RECALL: begin
                if (!good)          nxt = ST_RESET_HOLD;
                else if (walk_last) nxt = ST_RUN;
            end
            ST_RUN:           if (!good) nxt = ST_STORE;
            ST_STORE:         if (walk_last) nxt = good ? ST_RESUME : ST_SHUTDOWN_WAIT;
            ST_SHUTDOWN_WAIT: begin
                if (good)         nxt = ST_RESUME;
                else if (win_end) nxt = ST_RESET_HOLD;
            end
            ST_RESUME:        nxt = ST_RUN;
            default:          nxt = ST_RESET_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET_HOLD;
            win_q <= '0;
        end else begin
            state <= nxt;
            win_q <= (state == ST_SHUTDOWN_WAIT) ? win_q + WW'(1) : '0;
        end
    end
endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
    import pfs_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned FILT_LEN = 4,
    parameter int unsigned SHUT_WIN = 64,
    localparam int unsigned ADDR_W  = pfs_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok_async,
    output logic              sys_rst,
    output logic              nmi_n,
    output logic              mem_store,
    output logic              mem_recall,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              seq_done
);
    logic              good;
    pfs_state_e        state;
    pfs_cmd_t          cmd;
    logic              walking;
    logic [ADDR_W-1:0] walk_addr;
    logic              walk_last;

    pfs_sync_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .raw_in (pwr_ok_async),
        .level  (good)
    );

    pfs_walker #(.DEPTH(DEPTH)) u_walker (
        .clk  (clk),
        .rst  (rst),
        .run  (walking),
        .addr (walk_addr),
        .last (walk_last)
    );

    pfs_ctrl #(.SHUT_WIN(SHUT_WIN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .good      (good),
        .walk_last (walk_last),
        .state     (state)
    );

    assign walking    = pfs_walking(state);
    assign cmd        = pfs_decode(state);
    assign sys_rst    = cmd.sys_rst;
    assign nmi_n      = cmd.nmi_n;
    assign mem_store  = cmd.store;
    assign mem_recall = cmd.recall;
    assign mem_addr   = walking ? walk_addr : '0;
    assign seq_done   = walk_last;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = pfs_pkg::pfs_width(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          sys_rst,
    input logic          nmi_n,
    input logic          mem_store,
    input logic          mem_recall,
    input logic [AW-1:0] mem_addr,
    input logic          seq_done
);
    logic walk;
    assign walk = mem_store || mem_recall;

    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (sys_rst && nmi_n && !mem_store && !mem_recall && !seq_done));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_store && mem_recall));

    a_r10_idle_addr: assert property (@(posedge clk) disable iff (rst)
        !walk |-> (mem_addr == '0));

    a_r3_recall_in_reset: assert property (@(posedge clk) disable iff (rst)
        mem_recall |-> sys_rst);

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (walk && $past(mem_store || mem_recall) && !$past(seq_done))
            |-> (mem_addr == $past(mem_addr) + AW'(1)));

    a_r4_done_on_last: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (walk && mem_addr == AW'(DEPTH - 1)));

    a_r5_store_with_nmi: assert property (@(posedge clk) disable iff (rst)
        mem_store |-> (!nmi_n && !sys_rst));

    a_r6_no_reset_after_store: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_store) |-> !sys_rst);
endmodule

bind pfs_sequencer pfs_checker #(.DEPTH(DEPTH)) u_pfs_checker (
    .clk        (clk),
    .rst        (rst),
    .sys_rst    (sys_rst),
    .nmi_n      (nmi_n),
    .mem_store  (mem_store),
    .mem_recall (mem_recall),
    .mem_addr   (mem_addr),
    .seq_done   (seq_done)
);

// File: tb/test_pfs_sequencer.sv
`timescale 1ns/1ps
module test_pfs_sequencer;
    localparam int DEPTH = 16;
    localparam int FILT  = 4;
    localparam int WIN   = 64;
    localparam int AW    = $clog2(DEPTH);

    localparam int M_HOLD = 0, M_RECALL = 1, M_RUN = 2, M_STORE = 3, M_SHUT = 4, M_RESUME = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr = 1'b0;
    logic          sys_rst, nmi_n, mem_store, mem_recall, seq_done;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    pfs_sequencer #(.DEPTH(DEPTH), .FILT_LEN(FILT), .SHUT_WIN(WIN)) i_pfs_sequencer (
        .clk(clk), .rst(rst), .pwr_ok_async(pwr),
        .sys_rst(sys_rst), .nmi_n(nmi_n), .mem_store(mem_store),
        .mem_recall(mem_recall), .mem_addr(mem_addr), .seq_done(seq_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ram [DEPTH];
    logic [7:0] nv  [DEPTH];
    int store_cycles = 0;
    int rst_cycles   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < DEPTH; i++) if (ram[i] !== nv[i]) d++;
        return d;
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_st = M_HOLD, m_addr = 0, m_win = 0, m_run = 0, m_nx = 0;
    bit m_s1 = 0, m_s2 = 0, m_good = 0, m_walk = 0, m_last = 0, started = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_st = M_HOLD; m_addr = 0; m_win = 0; m_run = 0;
            m_s1 = 0; m_s2 = 0; m_good = 0;
        end else begin
            m_walk = (m_st == M_RECALL) || (m_st == M_STORE);
            m_last = m_walk && (m_addr == DEPTH - 1);
            m_nx = m_st;
            case (m_st)
                M_HOLD:   if (m_good) m_nx = M_RECALL;
                M_RECALL: if (!m_good) m_nx = M_HOLD; else if (m_last) m_nx = M_RUN;
                M_RUN:    if (!m_good) m_nx = M_STORE;
                M_STORE:  if (m_last) m_nx = m_good ? M_RESUME : M_SHUT;
                M_SHUT:   if (m_good) m_nx = M_RESUME; else if (m_win == WIN - 1) m_nx = M_HOLD;
                default:  m_nx = M_RUN;
            endcase
            m_win  = (m_st == M_SHUT) ? m_win + 1 : 0;
            m_addr = (m_walk && !m_last && m_nx == m_st) ? m_addr + 1 : 0;
            m_st   = m_nx;
            if (m_s2 == m_good) m_run = 0;
            else if (m_run == FILT - 1) begin m_good = m_s2; m_run = 0; end
            else m_run++;
            m_s2 = m_s1;
            m_s1 = pwr;
        end
    end

    // Memory model and per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (mem_store === 1'b1)  nv[mem_addr]  = ram[mem_addr];
        if (mem_recall === 1'b1) ram[mem_addr] = nv[mem_addr];
        if (mem_store === 1'b1) store_cycles++;
        if (sys_rst === 1'b1)   rst_cycles++;
        if (started) begin
            bit e_walk;
            e_walk = (m_st == M_RECALL) || (m_st == M_STORE);
            chk(sys_rst === (m_st == M_HOLD || m_st == M_RECALL), "R3 sys_rst", sys_rst,
                int'(m_st == M_HOLD || m_st == M_RECALL));
            chk(nmi_n === !(m_st == M_STORE || m_st == M_SHUT), "R5 nmi_n", nmi_n,
                int'(!(m_st == M_STORE || m_st == M_SHUT)));
            chk(mem_store === (m_st == M_STORE), "R5 mem_store", mem_store, int'(m_st == M_STORE));
            chk(mem_recall === (m_st == M_RECALL), "R3 mem_recall", mem_recall, int'(m_st == M_RECALL));
            chk(mem_addr === AW'(m_addr), "R3 mem_addr", int'(mem_addr), m_addr);
            chk(seq_done === (e_walk && m_addr == DEPTH - 1), "R4 seq_done", seq_done,
                int'(e_walk && m_addr == DEPTH - 1));
            chk(!(mem_store === 1'b1 && mem_recall === 1'b1), "R10 exclusive", int'(mem_store), 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin nv[i] = 8'(i * 7 + 3); ram[i] = 8'h00; end
        rst = 1'b1; pwr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sys_rst && nmi_n && !mem_store && !mem_recall && mem_addr == 0 && !seq_done,
            "R1 reset state", int'(sys_rst), 1);

        // R2: pulse one cycle shorter than the filter
        pwr = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        pwr = 1'b0;
        repeat (12) @(negedge clk);
        chk(sys_rst === 1'b1 && mem_recall === 1'b0, "R2 short pulse ignored", int'(mem_recall), 0);

        // R9: drop during restore
        pwr = 1'b1;
        for (int k = 0; k < 100 && !(mem_recall === 1'b1 && mem_addr == 3); k++) @(negedge clk);
        pwr = 1'b0;
        store_cycles = 0;
        repeat (FILT + 10) @(negedge clk);
        chk(mem_recall === 1'b0 && sys_rst === 1'b1, "R9 restore aborted", int'(mem_recall), 0);
        chk(store_cycles == 0, "R9 no store", store_cycles, 0);

        // R3: full restore
        pwr = 1'b1;
        for (int k = 0; k < 200 && sys_rst !== 1'b0; k++) @(negedge clk);
        chk(sys_rst === 1'b0, "R3 reset released", int'(sys_rst), 0);
        chk(mem_diff() == 0, "R3 RAM restored", mem_diff(), 0);

        // R5 + R7: store then short shutdown wait
        for (int i = 0; i < DEPTH; i++) ram[i] = 8'(8'hA0 + i);
        rst_cycles = 0; store_cycles = 0;
        pwr = 1'b0;
        for (int k = 0; k < 100 && nmi_n !== 1'b0; k++) @(negedge clk);
        chk(mem_store === 1'b1 && sys_rst === 1'b0, "R5 store starts with nmi", int'(mem_store), 1);
        for (int k = 0; k < 100 && seq_done !== 1'b1; k++) @(negedge clk);
        @(negedge clk);
        chk(mem_diff() == 0, "R5 image stored", mem_diff(), 0);
        chk(store_cycles == DEPTH, "R5 store length", store_cycles, DEPTH);
        repeat (5) @(negedge clk);
        pwr = 1'b1;
        for (int k = 0; k < 100 && nmi_n !== 1'b1; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(nmi_n === 1'b1 && sys_rst === 1'b0, "R7 resumed", int'(nmi_n), 1);
        chk(rst_cycles == 0, "R7 no reset", rst_cycles, 0);

        // R6: power returns while store runs
        for (int i = 0; i < DEPTH; i++) ram[i] = 8'(8'h50 ^ i);
        rst_cycles = 0; store_cycles = 0;
        pwr = 1'b0;
        repeat (FILT + 3) @(negedge clk);
        pwr = 1'b1;
        for (int k = 0; k < 100 && nmi_n !== 1'b0; k++) @(negedge clk);
        for (int k = 0; k < 100 && nmi_n !== 1'b1; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(store_cycles == DEPTH, "R6 store completed", store_cycles, DEPTH);
        chk(rst_cycles == 0, "R6 no reset", rst_cycles, 0);
        chk(mem_diff() == 0, "R6 image stored", mem_diff(), 0);

        // R8: true outage
        pwr = 1'b0;
        repeat (FILT + 3 + DEPTH + WIN + 10) @(negedge clk);
        chk(sys_rst === 1'b1 && nmi_n === 1'b1, "R8 outage ends in reset", int'(sys_rst), 1);
        for (int i = 0; i < DEPTH; i++) ram[i] = 8'h00;
        pwr = 1'b1;
        for (int k = 0; k < 200 && sys_rst !== 1'b0; k++) @(negedge clk);
        chk(sys_rst === 1'b0, "R8 reset released", int'(sys_rst), 0);
        chk(mem_diff() == 0, "R8 RAM restored", mem_diff(), 0);

        repeat (4) @(negedge clk);
        report();
    end
endmodule